// File: doc/BRIEF.md
# End-Around-Carry Modulo 2^N-1 Accumulator

This block adds a group of N-bit operands modulo 2^N-1 and returns one N-bit residue. It forms the accumulation back end of a Booth-recoded modulo multiplier. The block's inputs are:

- the partial-product vectors;
- one word that gathers all of the redundant carry bits;
- a compensation constant that cancels the bias the partial-product generator added.

The operands pass through a chain of 3:2 carry-save stages. Each stage wraps the carry from the top bit back into bit 0, so the word never grows past N bits. The last two words go to a two-operand modulo adder. That adder uses a Sklansky parallel-prefix carry network. It takes the overall group generate of the prefix tree as its own carry-in, so the end-around carry is resolved in a single pass with no second propagation.

The adder can produce the all-ones word, which is the second encoding of zero. The output register maps that word to all zeros. The result is registered and appears one clock after the matching `valid_i` strobe. It holds between strobes.

Top module: `mod_acc`

## Requirements
- R1: While rst_ni is low, and until the first accepted strobe, valid_o is 0 and res_o is 0.
- R2: A cycle with valid_i high at a rising clk_i edge gives valid_o high for exactly the following cycle. A cycle with valid_i low gives valid_o low in the following cycle.
- R3: The accepted result is the sum modulo 2^N-1 of three kinds of operand: the NUM_PP partial products, cw_i and cc_i. Partial product k is taken from pp_i[k*N +: N]. All operands are unsigned.
- R4: res_o is never all ones. A sum congruent to 0 is output as all zeros, for example when every operand is all ones.
- R5: A carry out of bit N-1 has weight 1. Two partial products equal to 2^(N-1), with all other operands 0, give 1.
- R6: Let B be a bias. Feed partial product k as B rotated left by 3k mod N. Feed cc_i as 2^N-1 minus the modulo 2^N-1 sum of those rotated biases. The result then equals cw_i mod 2^N-1.
- R7: Operands of 2^N-2 in every position give 2^N-1-(NUM_PP+2) when that value is non-negative.
- R8: While valid_i is low, changes on pp_i, cw_i and cc_i leave res_o unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand set present |
| pp_i | input | NUM_PP*N | Partial products, k-th at bits k*N +: N |
| cw_i | input | N | Merged redundant carry word |
| cc_i | input | N | Compensation constant |
| valid_o | output | 1 | Result present |
| res_o | output | N | Residue, 0 to 2^N-2 |

## Verification
Random operand sets check the full modulo sum against an independent wide-integer reference. A single wrapped top-bit carry, the all-ones and near-all-ones operand sets, and a sum of exactly 2^N-1 each target a different part of the logic:

- the wrapped carry checks the carry-save wrap;
- the all-ones and near-all-ones sets check the prefix end-around carry under full propagation;
- the sum of 2^N-1 checks the zero normalisation.

Rotated-bias operand sets with the matching constant show that the bias cancels and leaves only the carry word. Changing the inputs between strobes shows that the registered result holds.

// File: rtl/mod_acc_pkg.sv
package mod_acc_pkg;

  function automatic longint rotl(longint v, int r, int n);
    longint m;
    m = (longint'(1) << n) - 1;
    return ((v << r) | (v >> (n - r))) & m;
  endfunction

  // negation of the sum of all rotated biases, modulo 2^n-1
  function automatic longint comp_const(int n, int npp, longint bias);
    longint m, s;
    m = (longint'(1) << n) - 1;
    s = 0;
    for (int i = 0; i < npp; i++) s = (s + rotl(bias, (3 * i) % n, n)) % m;
    return m - s;
  endfunction

endpackage

// File: rtl/eac_csa.sv
module eac_csa #(
  parameter int N = 12
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic [N-1:0] c_i,
  output logic [N-1:0] s_o,
  output logic [N-1:0] c_o
);
  logic [N-1:0] maj;

  assign s_o = a_i ^ b_i ^ c_i;
  assign maj = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
  // top carry re-enters at bit 0
  assign c_o = {maj[N-2:0], maj[N-1]};
endmodule

// File: rtl/sklansky_eac_add.sv
module sklansky_eac_add #(
  parameter int N = 12
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [N-1:0] s_o
);
  localparam int LVL = $clog2(N);

  logic [LVL:0][N-1:0] gg;
  logic [LVL:0][N-1:0] pg;
  logic [N-1:0]        cy;
  logic                cin;

  assign gg[0] = a_i & b_i;
  assign pg[0] = a_i ^ b_i;

  for (genvar l = 0; l < LVL; l++) begin : g_lvl
    for (genvar i = 0; i < N; i++) begin : g_bit
      if (((i >> l) & 1) == 1) begin : g_op
        localparam int J = ((i >> l) << l) - 1;
        assign gg[l+1][i] = gg[l][i] | (pg[l][i] & gg[l][J]);
        assign pg[l+1][i] = pg[l][i] & pg[l][J];
      end else begin : g_pass
        assign gg[l+1][i] = gg[l][i];
        assign pg[l+1][i] = pg[l][i];
      end
    end
  end

  // group generate of the full word is the end-around carry-in
  assign cin = gg[LVL][N-1];
  assign cy[0] = cin;
  for (genvar i = 1; i < N; i++) begin : g_cy
    assign cy[i] = gg[LVL][i-1] | (pg[LVL][i-1] & cin);
  end

  assign s_o = pg[0] ^ cy;
endmodule

// File: rtl/mod_acc.sv
module mod_acc #(
  parameter int N      = 12,
  parameter int NUM_PP = N / 3 + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [NUM_PP*N-1:0]   pp_i,
  input  logic [N-1:0]          cw_i,
  input  logic [N-1:0]          cc_i,
  output logic                  valid_o,
  output logic [N-1:0]          res_o
);
  localparam int OPS = NUM_PP + 2;
  localparam int STG = OPS - 2;

  logic [OPS-1:0][N-1:0] op;
  logic [STG:0][N-1:0]   sv;
  logic [STG:0][N-1:0]   cv;
  logic [N-1:0]          raw;
  logic [N-1:0]          nrm;

  for (genvar k = 0; k < NUM_PP; k++) begin : g_op
    assign op[k] = pp_i[k*N +: N];
  end
  assign op[NUM_PP]   = cw_i;
  assign op[NUM_PP+1] = cc_i;

  assign sv[0] = op[0];
  assign cv[0] = op[1];

  for (genvar s = 0; s < STG; s++) begin : g_csa
    eac_csa #(.N(N)) csa_i (
      .a_i(sv[s]),
      .b_i(cv[s]),
      .c_i(op[s+2]),
      .s_o(sv[s+1]),
      .c_o(cv[s+1])
    );
  end

  sklansky_eac_add #(.N(N)) add_i (
    .a_i(sv[STG]),
    .b_i(cv[STG]),
    .s_o(raw)
  );

  // all ones is the redundant zero
  assign nrm = (&raw) ? '0 : raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) res_o <= nrm;
    end
  end
endmodule

// File: rtl/mod_acc_chk.sv
module mod_acc_chk #(
  parameter int N      = 12,
  parameter int NUM_PP = N / 3 + 1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_i,
  input logic [NUM_PP*N-1:0] pp_i,
  input logic [N-1:0]        cw_i,
  input logic [N-1:0]        cc_i,
  input logic                valid_o,
  input logic [N-1:0]        res_o
);
  // R2
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R2
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  // R8
  res_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o));

  // R4
  no_all_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&res_o));

  // R3
  zero_in_zero_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && pp_i == '0 && cw_i == '0 && cc_i == '0) |=> res_o == '0);
endmodule

bind mod_acc mod_acc_chk #(.N(N), .NUM_PP(NUM_PP)) chk_i (.*);

// File: tb/mod_acc_tb_top.sv
module mod_acc_tb_top;
  import mod_acc_pkg::*;

  localparam int N      = 12;
  localparam int NUM_PP = N / 3 + 1;
  localparam longint M  = (longint'(1) << N) - 1;

  typedef struct {
    longint exp;
    string  tag;
  } item_t;

  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic                valid_i = 1'b0;
  logic [NUM_PP*N-1:0] pp_i = '0;
  logic [N-1:0]        cw_i = '0;
  logic [N-1:0]        cc_i = '0;
  logic                valid_o;
  logic [N-1:0]        res_o;

  int checks = 0;
  int errors = 0;
  int popped = 0;
  item_t sb[$];

  always #2.5 clk_i = ~clk_i;

  mod_acc #(.N(N), .NUM_PP(NUM_PP)) dut_i (.*);

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // driver: one strobe, expectation pushed to the scoreboard
  task automatic drive(logic [NUM_PP*N-1:0] pp, logic [N-1:0] cw, logic [N-1:0] cc, string tag);
    longint s;
    item_t it;
    s = 0;
    for (int k = 0; k < NUM_PP; k++) s += longint'(pp[k*N +: N]);
    s += longint'(cw) + longint'(cc);
    it.exp = s % M;
    it.tag = tag;
    @(negedge clk_i);
    pp_i = pp; cw_i = cw; cc_i = cc; valid_i = 1'b1;
    sb.push_back(it);
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && valid_o) begin
        if (sb.size() == 0) begin
          check("R2 unexpected valid_o", 1, 0);
        end else begin
          item_t it;
          it = sb.pop_front();
          popped++;
          check(it.tag, longint'(res_o), it.exp);
        end
      end
    end
  end

  initial begin
    #(5 * 200000);
    check("watchdog", 1, 0);
    finish_run();
  end

  initial begin
    logic [NUM_PP*N-1:0] pp;
    logic [N-1:0] last;
    longint b;
    repeat (3) @(negedge clk_i);
    check("R1 valid_o in reset", longint'(valid_o), 0);
    check("R1 res_o in reset", longint'(res_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 valid_o after reset", longint'(valid_o), 0);
    check("R1 res_o after reset", longint'(res_o), 0);

    // R3 all zero
    drive('0, '0, '0, "R3 zero operands");
    // R5 top carry wrap
    pp = '0;
    pp[N-1] = 1'b1;
    pp[2*N-1] = 1'b1;
    drive(pp, '0, '0, "R5 wrapped carry");
    // R4 all ones
    drive('1, '1, '1, "R4 all ones to zero");
    // R4 sum equals modulus
    pp = '0;
    pp[N-1:0] = N'(M - 5);
    drive(pp, N'(5), '0, "R4 sum equals modulus");
    // R7 all operands 2^N-2
    for (int k = 0; k < NUM_PP; k++) pp[k*N +: N] = N'(M - 1);
    drive(pp, N'(M - 1), N'(M - 1), "R7 near all ones");
    @(negedge clk_i);
    check("R7 value", longint'(res_o), M - (NUM_PP + 2));
    // R6 bias cancel
    b = 'h111;
    for (int k = 0; k < NUM_PP; k++) pp[k*N +: N] = N'(rotl(b, (3 * k) % N, N));
    drive(pp, '0, N'(comp_const(N, NUM_PP, b)), "R6 bias cancel zero");
    @(negedge clk_i);
    check("R6 cancel value", longint'(res_o), 0);
    drive(pp, N'(12'h5a3), N'(comp_const(N, NUM_PP, b)), "R6 bias cancel carry word");
    @(negedge clk_i);
    check("R6 carry word value", longint'(res_o), 'h5a3);
    // R3 random
    for (int t = 0; t < 40; t++) begin
      for (int k = 0; k < NUM_PP; k++) pp[k*N +: N] = N'($urandom);
      drive(pp, N'($urandom), N'($urandom), "R3 random");
    end
    // R8 hold while idle
    @(negedge clk_i);
    last = res_o;
    for (int t = 0; t < 4; t++) begin
      pp_i = {NUM_PP{N'($urandom)}};
      cw_i = N'($urandom);
      cc_i = N'($urandom);
      @(negedge clk_i);
      check("R8 hold res_o", longint'(res_o), longint'(last));
      check("R2 idle valid_o", longint'(valid_o), 0);
    end
    // R2 back-to-back strobes
    @(negedge clk_i);
    valid_i = 1'b1; pp_i = '0; cw_i = N'(3); cc_i = '0;
    begin
      item_t it;
      it.exp = 3; it.tag = "R2 back-to-back first";
      sb.push_back(it);
    end
    @(negedge clk_i);
    cw_i = N'(9);
    begin
      item_t it;
      it.exp = 9; it.tag = "R2 back-to-back second";
      sb.push_back(it);
    end
    @(negedge clk_i);
    valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R2 scoreboard drained", longint'(sb.size()), 0);
    check("R2 results returned", longint'(popped), 49);
    finish_run();
  end
endmodule